// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept, working only from the six destination-address bytes at the head of the frame. The bytes arrive one per cycle, possibly with idle cycles between them, starting with the byte that goes on the wire first. After the last address byte is taken, the block gives a one-cycle done pulse and a held accept/reject decision.

Three enables choose the acceptance modes. Promiscuous mode accepts every frame. Broadcast frames are accepted only when their own enable is set. Group (multicast) frames must have their enable set and must also hit a 64-bit hash table, which is indexed by six bits of a CRC computed over the address bytes as they stream in. Any other frame is an individual address and is accepted only when it matches the programmed station address exactly. Frame payload and storage are handled by other logic.

Top module: `dst_addr_filter`

## Requirements
- R1: When `promisc_en_i` is 1, the decision is accept for every destination.
- R2: A destination whose six bytes are all 0xFF is broadcast. Without promiscuous mode, it is accepted exactly when `bcast_en_i` is 1, and the hash table and station address have no effect on it.
- R3: A destination that is not broadcast and whose first byte has bit 0 set is a group address. Without promiscuous mode, it is accepted only when `mcast_en_i` is 1 and the selected hash-table bit is 1.
- R4: The hash register is loaded with 0xFFFFFFFF and then takes each address byte in arrival order, bit 0 first. For each data bit d, the step is: carry = reg[31] XOR d; shift the register left by one; if carry is 1, XOR the register with 0x04C11DB6 and set bit 0. The index is reg[31:26] after the sixth byte, and it selects bit `hash_table_i[index]`, which is byte index[5:3] and bit index[2:0] within that byte.
- R5: Any other destination is accepted, without promiscuous mode, only if every byte equals the station address. Byte k of the address, counted in arrival order, is compared with `station_addr_i[8k+7:8k]`.
- R6: `done_o` is 1 for exactly one cycle, in the cycle that follows the clock edge taking the sixth address byte. `accept_o` shows the decision from that cycle onward. Idle cycles between bytes do not change the result.
- R7: Bytes presented after the sixth are ignored until the next frame start: `done_o` stays 0 and `accept_o` keeps its value.
- R8: `start_i` drops any partial frame and clears `accept_o` to 0. A byte presented in the same cycle as `start_i` is taken as the first byte of the new frame.
- R9: After reset, `done_o` and `accept_o` are 0, and the next byte presented is taken as the first byte of a frame.
- R10: The enables, station address and hash table are sampled on the edge that takes the sixth byte. Changes to them afterwards do not alter `accept_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start; restarts byte counting, CRC and compare state |
| byte_valid_i | input | 1 | Address byte present on `byte_i` |
| byte_i | input | 8 | Destination-address byte, first wire byte first |
| promisc_en_i | input | 1 | Accept all frames |
| bcast_en_i | input | 1 | Accept broadcast frames |
| mcast_en_i | input | 1 | Accept group frames that hit the hash table |
| station_addr_i | input | 48 | Station address, byte k at bits [8k+7:8k] |
| hash_table_i | input | 64 | Group hash table, bit n selected by hash index n |
| done_o | output | 1 | One-cycle strobe: decision is valid |
| accept_o | output | 1 | Accept decision, held until the next decision or start |

## Verification
The hardest case to reach from the ports is a group frame whose acceptance depends on a single hash-table bit. Random addresses spread the index across the table, but they rarely isolate the one selected bit. Directed cases therefore pair a group address with a table that has only its computed index set, and then with a table that has every bit set except that one, both with the group enable on. Random frames also mix in station copies, broadcasts and idle gaps, plus a restart in the middle of a frame.

// File: rtl/dst_filt_pkg.sv
package dst_filt_pkg;
  localparam int unsigned CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFF_FFFF;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;

  // one address byte, lsb first
  function automatic logic [CRC_W-1:0] crc_fold_byte(input logic [CRC_W-1:0] c_in,
                                                     input logic [7:0] b);
    logic [CRC_W-1:0] c;
    logic carry;
    c = c_in;
    for (int i = 0; i < 8; i++) begin
      carry = c[CRC_W-1] ^ b[i];
      c = {c[CRC_W-2:0], 1'b0};
      if (carry) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction
endpackage

// File: rtl/dst_filt_crc.sv
module dst_filt_crc
  import dst_filt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [7:0]       byte_i,
  output logic [CRC_W-1:0] crc_next_o
);
  logic [CRC_W-1:0] crc_q, crc_base;

  assign crc_base   = clr_i ? CRC_SEED : crc_q;
  assign crc_next_o = crc_fold_byte(crc_base, byte_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= CRC_SEED;
    else if (en_i)  crc_q <= crc_next_o;
    else if (clr_i) crc_q <= CRC_SEED;
  end

  AST_CRC_RESEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !en_i |=> crc_q == CRC_SEED);  // R8
  AST_CRC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i && !en_i |=> $stable(crc_q));  // R6
endmodule

// File: rtl/dst_filt_cmp.sv
module dst_filt_cmp #(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned IDX_W      = 3,
  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [7:0]        byte_i,
  input  logic [ADDR_W-1:0] station_i,
  output logic              ones_o,
  output logic              match_o,
  output logic              grp_o
);
  logic [7:0] st_byte [ADDR_BYTES];
  logic ones_q, match_q, grp_q;
  logic ones_b, match_b, grp_b;
  logic [7:0] st_sel;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_st
    assign st_byte[k] = station_i[8*k +: 8];
  end

  always_comb begin
    st_sel = 8'h00;
    for (int k = 0; k < ADDR_BYTES; k++)
      if (idx_i == IDX_W'(k)) st_sel = st_byte[k];
  end

  assign ones_b  = clr_i ? 1'b1 : ones_q;
  assign match_b = clr_i ? 1'b1 : match_q;
  assign grp_b   = clr_i ? 1'b0 : grp_q;

  assign ones_o  = ones_b & (byte_i == 8'hFF);
  assign match_o = match_b & (byte_i == st_sel);
  assign grp_o   = (idx_i == '0) ? byte_i[0] : grp_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q  <= 1'b1;
      match_q <= 1'b1;
      grp_q   <= 1'b0;
    end else if (en_i) begin
      ones_q  <= ones_o;
      match_q <= match_o;
      grp_q   <= grp_o;
    end else if (clr_i) begin
      ones_q  <= 1'b1;
      match_q <= 1'b1;
      grp_q   <= 1'b0;
    end
  end

  AST_MISMATCH_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !match_q |-> !match_o);  // R5
  AST_NOT_ONES_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && !ones_q |-> !ones_o);  // R2
endmodule

// File: rtl/dst_addr_filter.sv
module dst_addr_filter
  import dst_filt_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned HASH_BITS  = 6,
  localparam int unsigned ADDR_W    = 8 * ADDR_BYTES,
  localparam int unsigned TBL_W     = 2 ** HASH_BITS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              promisc_en_i,
  input  logic              bcast_en_i,
  input  logic              mcast_en_i,
  input  logic [ADDR_W-1:0] station_addr_i,
  input  logic [TBL_W-1:0]  hash_table_i,
  output logic              done_o,
  output logic              accept_o
);
  localparam int unsigned CNT_W = $clog2(ADDR_BYTES + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(ADDR_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ADDR_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cur_idx;
  logic take, last_byte;
  logic [CRC_W-1:0] crc_next;
  logic [HASH_BITS-1:0] hash_idx;
  logic hash_hit, is_ones, is_match, is_grp, decision;
  logic done_q, accept_q;

  assign cur_idx   = start_i ? '0 : cnt_q;
  assign take      = byte_valid_i && (cur_idx != CNT_FULL);
  assign last_byte = take && (cur_idx == CNT_LAST);

  dst_filt_crc i_crc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .en_i       (take),
    .byte_i     (byte_i),
    .crc_next_o (crc_next)
  );

  dst_filt_cmp #(.ADDR_BYTES(ADDR_BYTES), .IDX_W(CNT_W)) i_cmp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (start_i),
    .en_i      (take),
    .idx_i     (cur_idx),
    .byte_i    (byte_i),
    .station_i (station_addr_i),
    .ones_o    (is_ones),
    .match_o   (is_match),
    .grp_o     (is_grp)
  );

  assign hash_idx = crc_next[CRC_W-1 -: HASH_BITS];
  assign hash_hit = hash_table_i[hash_idx];

  // priority: promiscuous, broadcast, group, individual
  always_comb begin
    if (promisc_en_i)  decision = 1'b1;
    else if (is_ones)  decision = bcast_en_i;
    else if (is_grp)   decision = mcast_en_i & hash_hit;
    else               decision = is_match;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      done_q   <= 1'b0;
      accept_q <= 1'b0;
    end else begin
      cnt_q  <= take ? cur_idx + CNT_W'(1) : cur_idx;
      done_q <= last_byte;
      if (last_byte)    accept_q <= decision;
      else if (start_i) accept_q <= 1'b0;
    end
  end

  assign done_o   = done_q;
  assign accept_o = accept_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_FULL);  // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R6
  AST_ACCEPT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o && !$past(start_i) |-> $stable(accept_o));  // R7
  AST_PROMISC_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte && promisc_en_i |=> accept_o);  // R1
  AST_BCAST_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte && !promisc_en_i && is_ones |=> accept_o == $past(bcast_en_i));  // R2
  AST_GRP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte && !promisc_en_i && !is_ones && is_grp && !mcast_en_i |=> !accept_o);  // R3
  AST_UCAST_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_byte && !promisc_en_i && !is_ones && !is_grp |=> accept_o == $past(is_match));  // R5
endmodule

// File: tb/test_dst_addr_filter.sv
module test_dst_addr_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start, bvalid, p_en, b_en, m_en;
  logic [7:0] bdata;
  logic [47:0] station;
  logic [63:0] htab;
  logic done, accept;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  dst_addr_filter i_dst_addr_filter (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .byte_valid_i(bvalid),
    .byte_i(bdata), .promisc_en_i(p_en), .bcast_en_i(b_en), .mcast_en_i(m_en),
    .station_addr_i(station), .hash_table_i(htab), .done_o(done), .accept_o(accept)
  );

  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int k = 0; k < 6; k++)
      for (int i = 0; i < 8; i++) begin
        logic cy;
        cy = c[31] ^ a[8*k+i];
        c = c << 1;
        if (cy) c = (c ^ 32'h04C11DB6) | 32'h1;
      end
    return c[31:26];
  endfunction

  function automatic logic ref_accept(input logic [47:0] a, input logic p, input logic b,
                                      input logic m, input logic [47:0] st, input logic [63:0] ht);
    if (p) return 1'b1;
    if (a == '1) return b;
    if (a[0]) return m & ht[ref_index(a)];
    return a == st;
  endfunction

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", req, got, exp);
    end
  endtask

  // drives six bytes with optional idle gaps; sample at negedge after consuming edge
  task automatic send_addr(input logic [47:0] a, input int gap_max, input string req);
    for (int k = 0; k < 6; k++) begin
      int g = (gap_max > 0) ? int'($urandom % (gap_max + 1)) : 0;
      for (int j = 0; j < g; j++) begin
        @(negedge clk);
        start = 1'b0; bvalid = 1'b0;
        if (k > 0) chk({req, " R6 no done in gap"}, done, 1'b0);
      end
      @(negedge clk);
      start = (k == 0); bvalid = 1'b1; bdata = a[8*k +: 8];
    end
  endtask

  task automatic run_frame(input logic [47:0] a, input logic p, input logic b, input logic m,
                           input logic [47:0] st, input logic [63:0] ht, input int gap_max,
                           input string req);
    logic e;
    p_en = p; b_en = b; m_en = m; station = st; htab = ht;
    e = ref_accept(a, p, b, m, st, ht);
    send_addr(a, gap_max, req);
    @(negedge clk);
    start = 1'b0; bvalid = 1'b0;
    chk({req, " R6 done"}, done, 1'b1);
    chk(req, accept, e);
    @(negedge clk);
    chk({req, " R6 single pulse"}, done, 1'b0);
    chk({req, " R6 held"}, accept, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [47:0] st0, a;
    logic [63:0] ht;
    logic [5:0] ix;
    void'($urandom(32'd20240611));
    start = 0; bvalid = 0; bdata = 0; p_en = 0; b_en = 0; m_en = 0;
    station = '0; htab = '0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", done, 1'b0);
    chk("R9 reset accept", accept, 1'b0);
    rst_n = 1'b1;
    st0 = 48'h5544_3322_1100;

    // R9: first frame without start_i after reset
    p_en = 0; b_en = 0; m_en = 0; station = st0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); bvalid = 1'b1; bdata = st0[8*k +: 8];
    end
    @(negedge clk); bvalid = 1'b0;
    chk("R9 first frame done", done, 1'b1);
    chk("R9 first frame accept", accept, 1'b1);

    // R5 directed
    run_frame(st0, 0, 0, 0, st0, '0, 0, "R5 exact match");
    run_frame(st0 ^ 48'h0100_0000_0000, 0, 1, 1, st0, '1, 0, "R5 last byte differs");
    run_frame(st0 ^ 48'h0000_0000_0002, 0, 1, 1, st0, '1, 0, "R5 first byte differs");
    // R1
    run_frame(48'h1234_5678_9A02, 1, 0, 0, st0, '0, 0, "R1 promisc unicast");
    run_frame('1, 1, 0, 0, st0, '0, 0, "R1 promisc broadcast");
    // R2
    run_frame('1, 0, 1, 0, st0, '0, 0, "R2 broadcast enabled");
    run_frame('1, 0, 0, 1, '1, '1, 0, "R2 broadcast disabled");
    // R3 / R4: isolate the selected bit
    a = 48'h0000_5E00_0001;
    ix = ref_index(a);
    ht = 64'd1 << ix;
    run_frame(a, 0, 0, 1, st0, ht, 0, "R4 only indexed bit set");
    run_frame(a, 0, 0, 1, st0, ~ht, 0, "R4 all but indexed bit");
    run_frame(a, 0, 1, 0, st0, '1, 0, "R3 group disabled");
    run_frame(48'hFFFF_FFFF_FF01, 0, 1, 1, st0, ht, 0, "R3 near-broadcast group");

    // R7 extra bytes ignored; R10 late config change
    run_frame(st0, 0, 0, 0, st0, '0, 0, "R7 setup");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); bvalid = 1'b1; bdata = 8'hA5; station = ~st0; p_en = 0;
      if (k > 0) chk("R7 extra byte no done", done, 1'b0);
    end
    @(negedge clk); bvalid = 1'b0;
    chk("R7 extra byte no done", done, 1'b0);
    chk("R10 accept unchanged", accept, 1'b1);

    // R8 start alone clears accept
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R8 start clears accept", accept, 1'b0);
    chk("R8 start no done", done, 1'b0);

    // R8 restart mid-frame
    station = st0; p_en = 0; b_en = 0; m_en = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); start = (k == 0); bvalid = 1'b1; bdata = 8'hEE;
    end
    run_frame(st0, 0, 0, 0, st0, '0, 0, "R8 restart mid-frame");

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [47:0] st, ad;
      int kind;
      st = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
      kind = $urandom % 4;
      case (kind)
        0: ad = st;
        1: ad = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFE;
        2: ad = {$urandom, $urandom} | 48'h1;
        default: ad = '1;
      endcase
      run_frame(ad, ($urandom % 8) == 0, $urandom % 2, $urandom % 2, st,
                {$urandom, $urandom}, 2, "R3 R5 random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule